// File: doc/BRIEF.md
# Multiframe Clock Alignment Unit

This block turns a device clock into two periodic timing strobes: a frame strobe that marks the first octet of every frame, and a multiframe strobe that marks the first octet of every multiframe. One octet passes per device-clock cycle. A frame holds F octets and a multiframe holds K frames, so the multiframe strobe repeats every K×F cycles. Both counters run freely from reset. A rising edge on the external alignment reference (SYSREF) resets both counters to a known phase. This removes the start-up phase ambiguity of the internal divider and lines up the multiframe clocks of several devices that share the reference.

The reference is synchronised with two registers. It then passes through a programmable delay of whole cycles, which trims its capture timing. Only rising edges count. The first accepted edge sets the phase and raises the aligned flag. Once the block is aligned, a later edge is checked against the running phase. If the edge agrees with the phase (a periodic or gapped reference whose period is a whole number of multiframes), nothing changes. If the edge would land inside a multiframe, the phase is kept and a sticky error flag is raised. Software can mask the reference once alignment is reached, so a periodic reference can be switched off in normal operation.

The block carries no data path, so every pin is a plain level or strobe with no handshake. K and F are programmed as count minus one, which keeps zero out of range.

Top module: `lmfc_align`

## Requirements
- R1: While reset is held and in the first cycle after reset, `frame_strobe` and `lmfc_strobe` are 1, `aligned` is 0 and `sysref_err` is 0.
- R2: Without an accepted reference edge, `frame_strobe` is high once every F = `octets_m1`+1 cycles and `lmfc_strobe` is high once every K×F cycles (K = `frames_m1`+1). The first of each falls in the first cycle after reset, and `lmfc_strobe` is only high together with `frame_strobe`.
- R3: If `sysref_in` is first sampled high at clock edge P after having been low, and the edge is accepted, both strobes are high in the cycle after edge P+3+D and repeat with periods F and K×F from there. `aligned` becomes 1 in that same cycle. D is the delay of R4.
- R4: `sysref_dly` adds D = `sysref_dly` whole cycles (0 to 2^width−1) to the capture timing of R3.
- R5: When `aligned` is 1, an edge that would realign to the phase already running (including a continuous square-wave reference whose period is a multiple of K×F) changes neither the strobes nor the flags.
- R6: When `aligned` is 1, an edge that would realign to any other phase is rejected. The strobes keep their phase, and `sysref_err` becomes 1 in the cycle after edge P+3+D and stays 1.
- R7: While `sysref_en` is 0, reference edges have no effect on the strobes, `aligned` or `sysref_err`.
- R8: A change of `frames_m1` or `octets_m1` clears `aligned` and `sysref_err` in the cycle after the next clock edge. A later edge then realigns with the new K and F as in R3.
- R9: A reference held high counts as one edge only. Neither the level nor its falling edge causes a further realignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock; one octet per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| sysref_in | input | 1 | External alignment reference |
| sysref_en | input | 1 | 1 = reference edges are acted on |
| sysref_dly | input | DLY_W | Extra capture delay in whole cycles |
| frames_m1 | input | K_W | Frames per multiframe minus one |
| octets_m1 | input | F_W | Octets per frame minus one |
| frame_strobe | output | 1 | High in the first octet cycle of each frame |
| lmfc_strobe | output | 1 | High in the first octet cycle of each multiframe |
| aligned | output | 1 | A reference edge has set the phase since reset or the last change of K or F |
| sysref_err | output | 1 | Sticky: a reference edge fell inside a multiframe |

## Verification
A wrong count in the capture path moves the realigned strobes by whole cycles. This shows at the ports within 3+D cycles of the edge. A wrong wrap value shows up as a strobe period other than F or K×F, within one multiframe. A faulty consistency test shows up in one of two ways: a false `sysref_err`, or a strobe phase that moves under a periodic reference, in the cycle after edge P+3+D. The bench sweeps every K and F from one to three against several delays and compares each cycle's strobes with arithmetic residues of the cycle count.

// File: rtl/lmfc_pkg.sv
package lmfc_pkg;
  // Outcome of one detected reference edge.
  typedef enum logic [1:0] {
    SR_NONE,     // no edge this cycle
    SR_ADOPT,    // not aligned yet: take the edge as the phase
    SR_CONFIRM,  // aligned and edge agrees with running phase
    SR_REJECT    // aligned and edge would land inside a multiframe
  } sr_verdict_t;
endpackage

// File: rtl/sysref_capture.sv
module sysref_capture #(
  parameter int DLY_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sysref_in,
  input  logic             enable,
  input  logic [DLY_W-1:0] dly,
  output logic             event_o
);
  localparam int TAPS = (1 << DLY_W) - 1;

  logic            s1, s2, prev, delayed;
  logic [TAPS-1:0] tap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= sysref_in;
      s2 <= s1;
    end
  end

  generate
    if (TAPS == 1) begin : g_one_tap
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tap <= '0;
        else        tap <= s2;
      end
    end else begin : g_tap_line
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tap <= '0;
        else        tap <= {tap[TAPS-2:0], s2};
      end
    end
  endgenerate

  always_comb begin
    delayed = s2;
    for (int i = 1; i <= TAPS; i++)
      if (int'(dly) == i) delayed = tap[i-1];
  end

  // Rising edge after the delay, registered: one cycle wide.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev    <= 1'b0;
      event_o <= 1'b0;
    end else begin
      prev    <= delayed;
      event_o <= delayed & ~prev & enable;
    end
  end

  // R9: an event is never followed directly by another one
  assert_single_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    event_o |=> !event_o)
    else $error("reference event repeated on consecutive cycles");
endmodule

// File: rtl/lmfc_counter.sv
module lmfc_counter #(
  parameter int K_W = 5,
  parameter int F_W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [K_W-1:0] k_m1,
  input  logic [F_W-1:0] f_m1,
  input  logic           load,
  output logic           at_last,
  output logic           frame_strobe,
  output logic           lmfc_strobe
);
  logic [F_W-1:0] octet;
  logic [K_W-1:0] frame;
  logic           oct_last, frm_last;

  // Compare with >= so a shrunk K or F wraps at once.
  assign oct_last = (octet >= f_m1);
  assign frm_last = (frame >= k_m1);
  assign at_last  = oct_last && frm_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      octet <= '0;
      frame <= '0;
    end else if (load || at_last) begin
      octet <= '0;
      frame <= '0;
    end else if (oct_last) begin
      octet <= '0;
      frame <= frame + K_W'(1);
    end else begin
      octet <= octet + F_W'(1);
    end
  end

  assign frame_strobe = (octet == '0);
  assign lmfc_strobe  = (octet == '0) && (frame == '0);

  // R2: multiframe strobe is not repeated back to back unless K*F is one
  assert_lmfc_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lmfc_strobe && !load && (k_m1 != '0 || f_m1 != '0)) |=> !lmfc_strobe)
    else $error("multiframe strobe repeated early");

  // R2: frame strobe is not repeated back to back unless F is one
  assert_frame_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_strobe && !load && f_m1 != '0) |=> !frame_strobe)
    else $error("frame strobe repeated early");
endmodule

// File: rtl/align_ctrl.sv
module align_ctrl
  import lmfc_pkg::*;
#(
  parameter int K_W = 5,
  parameter int F_W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           event_i,
  input  logic           at_last,
  input  logic [K_W-1:0] k_m1,
  input  logic [F_W-1:0] f_m1,
  output logic           load,
  output logic           aligned,
  output logic           sysref_err
);
  localparam int CFG_W = K_W + F_W;

  logic [CFG_W-1:0] cfg_q;
  logic             cfg_change;
  sr_verdict_t      verdict;

  assign cfg_change = ({k_m1, f_m1} != cfg_q);

  always_comb begin
    if (!event_i)      verdict = SR_NONE;
    else if (!aligned) verdict = SR_ADOPT;
    else if (at_last)  verdict = SR_CONFIRM;
    else               verdict = SR_REJECT;
  end

  assign load = (verdict == SR_ADOPT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q      <= '0;
      aligned    <= 1'b0;
      sysref_err <= 1'b0;
    end else begin
      cfg_q <= {k_m1, f_m1};
      if (cfg_change) begin
        aligned    <= 1'b0;
        sysref_err <= 1'b0;
      end else begin
        case (verdict)
          SR_ADOPT:  aligned    <= 1'b1;
          SR_REJECT: sysref_err <= 1'b1;
          default:   ;
        endcase
      end
    end
  end

  // R6: an error only appears while aligned
  assert_err_needs_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sysref_err) |-> aligned)
    else $error("error raised while not aligned");

  // R6: a rejected edge always leaves the error set
  assert_reject_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (event_i && aligned && !at_last && !cfg_change) |=> sysref_err)
    else $error("misplaced edge not flagged");

  // R8: a configuration change clears both flags
  assert_cfg_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_change |=> (!aligned && !sysref_err))
    else $error("flags survived configuration change");
endmodule

// File: rtl/lmfc_align.sv
module lmfc_align #(
  parameter int K_W   = 5,
  parameter int F_W   = 4,
  parameter int DLY_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sysref_in,
  input  logic             sysref_en,
  input  logic [DLY_W-1:0] sysref_dly,
  input  logic [K_W-1:0]   frames_m1,
  input  logic [F_W-1:0]   octets_m1,
  output logic             frame_strobe,
  output logic             lmfc_strobe,
  output logic             aligned,
  output logic             sysref_err
);
  logic ev, at_last, load;

  sysref_capture #(.DLY_W(DLY_W)) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .sysref_in (sysref_in),
    .enable    (sysref_en),
    .dly       (sysref_dly),
    .event_o   (ev)
  );

  lmfc_counter #(.K_W(K_W), .F_W(F_W)) u_counter (
    .clk          (clk),
    .rst_n        (rst_n),
    .k_m1         (frames_m1),
    .f_m1         (octets_m1),
    .load         (load),
    .at_last      (at_last),
    .frame_strobe (frame_strobe),
    .lmfc_strobe  (lmfc_strobe)
  );

  align_ctrl #(.K_W(K_W), .F_W(F_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .event_i    (ev),
    .at_last    (at_last),
    .k_m1       (frames_m1),
    .f_m1       (octets_m1),
    .load       (load),
    .aligned    (aligned),
    .sysref_err (sysref_err)
  );

  // R3: alignment starts exactly on a multiframe and frame boundary
  assert_align_on_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aligned) |-> (lmfc_strobe && frame_strobe))
    else $error("alignment not on a multiframe boundary");

  // R2: multiframe start is always also a frame start
  assert_lmfc_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lmfc_strobe |-> frame_strobe)
    else $error("multiframe strobe without frame strobe");
endmodule

// File: tb/lmfc_align_bench.sv
`timescale 1ns/1ps
module lmfc_align_bench;
  localparam int K_W = 5, F_W = 4, D_W = 3;

  logic clk = 1'b0, rst_n = 1'b0, sysref = 1'b0, sr_en = 1'b1;
  logic [D_W-1:0] dly = '0;
  logic [K_W-1:0] km1 = '0;
  logic [F_W-1:0] fm1 = '0;
  logic frame_strobe, lmfc_strobe, aligned, sysref_err;

  lmfc_align #(.K_W(K_W), .F_W(F_W), .DLY_W(D_W)) u_lmfc_align (
    .clk(clk), .rst_n(rst_n), .sysref_in(sysref), .sysref_en(sr_en),
    .sysref_dly(dly), .frames_m1(km1), .octets_m1(fm1),
    .frame_strobe(frame_strobe), .lmfc_strobe(lmfc_strobe),
    .aligned(aligned), .sysref_err(sysref_err));

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0, t_rel = 0;

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) step();
  endtask

  task automatic do_reset(input int k, input int f, input int d);
    rst_n = 1'b0; km1 = K_W'(k); fm1 = F_W'(f); dly = D_W'(d);
    sysref = 1'b0; sr_en = 1'b1;
    repeat (3) step();
    rst_n = 1'b1;
    t_rel = cyc;
  endtask

  task automatic pulse(input int width, output int p);
    sysref = 1'b1;
    p = cyc + 1;
    repeat (width) step();
    sysref = 1'b0;
  endtask

  function automatic int modn(input int a, input int n);
    int r;
    r = a % n;
    if (r < 0) r += n;
    return r;
  endfunction

  function automatic int mf_len();
    return (int'(km1) + 1) * (int'(fm1) + 1);
  endfunction

  // Compares strobes and flags every cycle of a window against phase t0.
  task automatic check_phase(input int t0, input int n_cyc, input string tag,
                             input logic exp_al, input logic exp_err);
    int nn, ff;
    logic bad, el, ef;
    nn = mf_len();
    ff = int'(fm1) + 1;
    bad = 1'b0;
    for (int i = 0; i < n_cyc; i++) begin
      ef = (modn(cyc - t0, ff) == 0);
      el = (modn(cyc - t0, nn) == 0);
      if (!bad && (lmfc_strobe !== el || frame_strobe !== ef ||
                   aligned !== exp_al || sysref_err !== exp_err)) begin
        bad = 1'b1;
        $display("FAIL %s cycle %0d: lmfc,frame,aligned,err = %b%b%b%b expected %b%b%b%b",
                 tag, cyc, lmfc_strobe, frame_strobe, aligned, sysref_err,
                 el, ef, exp_al, exp_err);
      end
      step();
    end
    n_chk++;
    if (bad) n_fail++;
  endtask

  task automatic check_flags(input logic exp_al, input logic exp_err, input string tag);
    n_chk++;
    if (aligned !== exp_al || sysref_err !== exp_err) begin
      n_fail++;
      $display("FAIL %s: aligned,err = %b%b expected %b%b",
               tag, aligned, sysref_err, exp_al, exp_err);
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int p, t0, t1, nn, dd;

    // R1 reset state, R2 free-running strobes
    do_reset(2, 1, 0);
    check_phase(t_rel, 1, "R1 reset state", 1'b0, 1'b0);
    check_phase(t_rel, 3 * mf_len(), "R2 free run K=3 F=2", 1'b0, 1'b0);

    // R3 R4: sweep K, F in 1..3 and delays 0,1,2,7
    for (int k = 0; k < 3; k++)
      for (int f = 0; f < 3; f++)
        for (int di = 0; di < 4; di++) begin
          dd = (di == 3) ? 7 : di;
          do_reset(k, f, dd);
          repeat (k + 2 * f + di + 1) step();
          pulse(1, p);
          t0 = p + 3 + dd;
          wait_until(t0);
          check_phase(t0, 2 * mf_len() + 2,
                      $sformatf("R3 R4 sweep K=%0d F=%0d D=%0d", k + 1, f + 1, dd),
                      1'b1, 1'b0);
        end

    // R5: gapped and continuous periodic reference, K=2 F=3 D=1
    do_reset(1, 2, 1);
    nn = mf_len();
    repeat (2) step();
    pulse(1, p);
    t0 = p + 4;
    wait_until(t0);
    check_phase(t0, nn, "R3 first alignment", 1'b1, 1'b0);
    p = t0 + 3 * nn - 4;
    wait_until(p - 1);
    pulse(1, t1);
    wait_until(p + 4);
    check_phase(t0, 2 * nn, "R5 gapped pulse on boundary", 1'b1, 1'b0);
    p = t0 + 8 * nn - 4;
    wait_until(p - 1);
    for (int r = 0; r < 4; r++) begin
      sysref = 1'b1; repeat (nn) step();
      sysref = 1'b0; repeat (nn) step();
    end
    check_phase(t0, 2 * nn, "R5 continuous periodic reference", 1'b1, 1'b0);

    // R6: misplaced pulse
    p = cyc + 2;
    while (modn(p + 4 - t0, nn) != 2) p++;
    wait_until(p - 1);
    pulse(1, t1);
    wait_until(p + 3);
    check_phase(t0, 1, "R6 error not yet set", 1'b1, 1'b0);
    check_phase(t0, 2 * nn, "R6 rejected pulse keeps phase", 1'b1, 1'b1);

    // R8: change F from 3 to 2
    fm1 = F_W'(1);
    step();
    check_flags(1'b0, 1'b0, "R8 flags cleared by config change");
    nn = mf_len();
    pulse(1, p);
    t1 = p + 4;
    wait_until(t1);
    check_phase(t1, 2 * nn, "R8 realign with new F", 1'b1, 1'b0);

    // R7: disabled capture while aligned
    sr_en = 1'b0;
    p = cyc + 2;
    while (modn(p + 4 - t1, nn) != 1) p++;
    wait_until(p - 1);
    pulse(1, t0);
    wait_until(p + 4);
    check_phase(t1, 2 * nn, "R7 disabled edge ignored when aligned", 1'b1, 1'b0);

    // R7: disabled capture before alignment
    do_reset(1, 1, 0);
    sr_en = 1'b0;
    nn = mf_len();
    step();
    pulse(1, p);
    check_phase(t_rel, 3 * nn, "R7 disabled edge ignored unaligned", 1'b0, 1'b0);

    // R9: held level gives one event, falling edge none
    sr_en = 1'b1;
    step();
    sysref = 1'b1;
    p = cyc + 1;
    wait_until(p + 3);
    check_phase(p + 3, 4 * nn + 1, "R9 held level aligns once", 1'b1, 1'b0);
    sysref = 1'b0;
    check_phase(p + 3, 3 * nn, "R9 falling edge no event", 1'b1, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule